// File: doc/BRIEF.md
# Message Interrupt Pending Bank

This block keeps eight 32-bit pending words for message-signalled interrupts. A device posts a message with a single write to an index register. The write data packs two fields: a 3-bit selector that picks one of the eight words, and a 5-bit bit number within that word. The addressed bit is set and any bits already pending stay set. Each pending word drives its own interrupt request line. The line is a level that stays high for as long as the word holds any set bit.

Software collects pending messages by reading a word. The read returns the word's contents and empties it in the same access, so the matching request line falls on the next cycle. A summary register has one flag per word, set when that word is non-empty, so a handler can find work without side effects.

Access uses separate write and read channels, each with a byte offset. Only full 32-bit words are transferred. A read returns its data combinationally in the cycle its enable is high, and any clear takes effect at the clock edge that ends that cycle.

Top module: `msi_bank`

## Requirements
- R1: After reset all eight pending words are zero and every bit of `irq_o` is low.
- R2: A write to offset 0x140 sets bit `wr_data[28:24]` of pending word `wr_data[31:29]`. Bits already set in that word keep their value, and the other bits of `wr_data` have no effect.
- R3: Bit i of `irq_o` is high from the cycle after a write sets a bit in word i, and stays high while word i is non-zero.
- R4: A read at offset 0x10*i (i = 0..7) returns word i and clears it. Bit i of `irq_o` is low from the next cycle, and a second read returns zero.
- R5: A read at offset 0x120 returns, in bit i, a one exactly when word i is non-zero, with zeros in bits 31:8. The read changes no pending state.
- R6: A write whose offset has a non-zero low nibble is ignored. A read whose offset has a non-zero low nibble returns 0xFFFFFFFF and clears nothing.
- R7: A write to any aligned offset other than 0x140 is ignored.
- R8: An aligned read of an offset that holds no readable register (including 0x80 and 0x140) returns zero.
- R9: When, in one cycle, a write sets a bit in word i and a read clears word i, the read returns the old contents and the new bit remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of a pending word clears it at the clock edge |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 8 | Per-word interrupt request levels |

## Verification
Messages are posted to a single word, repeated onto an already-set bit, spread across the two end words (0 and 7), and finally one distinct bit per word for all eight words. These cases separate a correct OR-accumulate from an overwrite and show that the selector and bit fields are decoded from the right positions. Reads are then issued to pending words, to the summary, to misaligned offsets, to unmapped aligned offsets and to the index register. Comparing the data returned with what is left afterwards tells apart a clearing read, a non-destructive read and a read that must clear nothing. A same-cycle post and clear of one word checks that the new bit wins over the clear, and a reset in the middle of a run checks that all pending state is dropped.

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int NUM_REGS   = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 4,
  parameter int INDEX_OFS  = 'h140,
  parameter int SUMMARY_OFS = 'h120,
  parameter int SEL_LSB    = 29,
  parameter int BIT_LSB    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_REGS-1:0] irq_o
);
  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int PEND_END = NUM_REGS << STRIDE_LSB;

  logic [DATA_W-1:0] pend [NUM_REGS];
  logic [NUM_REGS-1:0] nz;

  logic wr_aligned, rd_aligned, idx_wr, rd_pend;
  logic [SEL_W-1:0] set_sel, rd_reg;
  logic [BIT_W-1:0] set_bit;
  logic unused_ok;

  assign wr_aligned = wr_addr[STRIDE_LSB-1:0] == '0;
  assign rd_aligned = rd_addr[STRIDE_LSB-1:0] == '0;
  assign idx_wr     = wr_en && wr_aligned && (32'(wr_addr) == INDEX_OFS);
  assign set_sel    = wr_data[SEL_LSB +: SEL_W];
  assign set_bit    = wr_data[BIT_LSB +: BIT_W];
  assign rd_reg     = rd_addr[STRIDE_LSB +: SEL_W];
  assign rd_pend    = rd_en && rd_aligned && (32'(rd_addr) < PEND_END);
  assign unused_ok  = ^{wr_data[BIT_LSB-1:0]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit_set, hit_clr;
    assign hit_set = idx_wr && (set_sel == SEL_W'(g));
    assign hit_clr = rd_pend && (rd_reg == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) pend[g] <= '0;
      else pend[g] <= (hit_clr ? '0 : pend[g]) |
                      (hit_set ? (DATA_W'(1) << set_bit) : '0);
    end
    assign nz[g] = |pend[g];
  end

  assign irq_o = nz;

  always_comb begin
    if (!rd_aligned)                          rd_data = '1;
    else if (32'(rd_addr) < PEND_END)         rd_data = pend[rd_reg];
    else if (32'(rd_addr) == SUMMARY_OFS)     rd_data = DATA_W'(nz);
    else                                      rd_data = '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> irq_o == '0);

  assert_post_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> irq_o[$past(set_sel)]);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !(idx_wr && set_sel == rd_reg)) |=> !irq_o[$past(rd_reg)]);

  assert_summary_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && 32'(rd_addr) == SUMMARY_OFS && !wr_en) |=> $stable(irq_o));

  assert_misaligned_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_aligned) |-> rd_data == '1);

  assert_misaligned_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_aligned && !rd_en) |=> $stable(irq_o));

  assert_merge_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && idx_wr && set_sel == rd_reg) |=>
      pend[$past(rd_reg)] == (DATA_W'(1) << $past(set_bit)));
endmodule

// File: tb/msi_bank_tb.sv
`timescale 1ns/1ps
module msi_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_o;

  int checks = 0, errors = 0;
  logic [31:0] model [8];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  msi_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [7:0] model_irq();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = |model[i];
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk); #1;
    chk({24'h0, irq_o}, {24'h0, model_irq()}, tag);
  endtask

  // monitor: pops expected read data in the cycle a read is presented
  always begin
    @(negedge clk); #2;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual read %h expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic post(input int r, input int b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h140;
    wr_data = (32'(r) << 29) | (32'(b) << 24) | 32'h00A5_5A5A;
    model[r] = model[r] | (32'h1 << b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic raw_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_pend(input int r, input string tag);
    rd(12'(r << 4), model[r], tag);
    model[r] = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq("R1 irq after reset");
    rd(12'h120, 32'h0, "R1 summary after reset");

    post(3, 5);
    chk_irq("R3 irq after single post");
    post(3, 5);
    post(3, 31);
    rd(12'h120, 32'h08, "R5 summary one word");
    chk_irq("R5 irq unchanged by summary read");
    rd_pend(3, "R2 accumulate word 3");
    chk_irq("R4 irq falls after read");
    rd(12'h030, 32'h0, "R4 second read empty");

    post(0, 0);
    post(7, 31);
    chk_irq("R3 irq end words");
    rd(12'h120, 32'h81, "R5 summary end words");

    raw_wr(12'h144, 32'h4000_0000);
    raw_wr(12'h14C, 32'h2300_0000);
    chk_irq("R6 misaligned write ignored");
    rd(12'h004, 32'hFFFF_FFFF, "R6 misaligned read ones");
    rd(12'h071, 32'hFFFF_FFFF, "R6 misaligned read ones near word 7");
    rd(12'h000, 32'h1, "R6 misaligned read cleared nothing");
    model[0] = '0;

    raw_wr(12'h120, 32'hFFFF_FFFF);
    raw_wr(12'h020, 32'h4500_0000);
    raw_wr(12'h000, 32'h0100_0000);
    chk_irq("R7 other writes ignored");
    rd(12'h080, 32'h0, "R8 unmapped 0x80");
    rd(12'h140, 32'h0, "R8 index register reads zero");
    rd(12'h200, 32'h0, "R8 unmapped 0x200");

    // R9: post and clear of word 7 in the same cycle
    @(negedge clk);
    exp_q.push_back(32'h8000_0000); tag_q.push_back("R9 merged read old value");
    wr_en = 1'b1; wr_addr = 12'h140; wr_data = (32'd7 << 29) | (32'd2 << 24);
    rd_en = 1'b1; rd_addr = 12'h070;
    model[7] = 32'h4;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk_irq("R9 new bit keeps irq");
    rd_pend(7, "R9 new bit survives");
    chk_irq("R4 irq clear after merge");

    for (int r = 0; r < 8; r++) post(r, (r * 4 + 1) % 32);
    chk_irq("R3 all lines");
    rd(12'h120, 32'hFF, "R5 summary all words");
    for (int r = 0; r < 8; r++) rd_pend(r, "R2 field decode per word");
    chk_irq("R4 all cleared");

    post(2, 9);
    post(5, 17);
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk); rst_n = 1'b1;
    chk_irq("R1 reset mid run");
    rd(12'h120, 32'h0, "R1 summary after mid reset");
    rd(12'h020, 32'h0, "R1 word 2 empty after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule